// File: doc/BRIEF.md
# Dual-Direction Mailbox Bypass

This block gives two ports on unrelated clocks a side channel for single words, so that they do not have to pass through a shared FIFO. Port A posts a word into mailbox 1, and port B collects it. Port B posts a word into mailbox 2, and port A collects it. Each port has a mailbox-select input. When it is high, that port's chip-select, enable and write/read strobes reach the mailboxes. When it is low, the access belongs to the FIFO path, which lies outside this block, and the mailboxes ignore it.

Each mailbox has two active-low status flags:

- A full flag in the writer's clock domain. It blocks a second post until the reader has taken the first word.
- A waiting flag in the reader's clock domain. It shows that a word is ready to collect.

The two domains hand off with a toggle event that is passed through a synchronizer of `SYNC` flops. The data word itself never crosses through flops. It is held stable while its mailbox is full, and the reader samples it only after the synchronized post event has arrived.

Top module: `dual_mailbox`

## Requirements
- R1: While `rst_n` is low, both full flags and both waiting flags are high (inactive), and `a_dout` and `b_dout` are zero.
- R2: A port A post happens on a `clk_a` rising edge with `a_cs`=1, `a_en`=1, `a_mb`=1 and `a_wr`=1 while `a_mb1_full_n` is high. It stores `a_din` in mailbox 1, and `a_mb1_full_n` is low right after that edge.
- R3: After a post to mailbox 1, `b_mb1_wait_n` goes low within `SYNC`+1 rising edges of `clk_b`.
- R4: A port B collect happens on a `clk_b` edge with `b_cs`=1, `b_en`=1, `b_mb`=1 and `b_wr`=0 while `b_mb1_wait_n` is low. It loads `b_dout` with the mailbox 1 word and drives `b_mb1_wait_n` high right after that edge. `a_mb1_full_n` then returns high within `SYNC`+1 rising edges of `clk_a`.
- R5: A post to mailbox 1 while `a_mb1_full_n` is low is ignored. The word already held stays intact and is the one collected.
- R6: A collect from a mailbox whose waiting flag is high has no effect. The reading port's output keeps its previous value.
- R7: Any access with the mailbox select low, or with chip-select or enable low, changes no mailbox, flag or output.
- R8: Mailbox 2 behaves as R2 to R6 with the ports swapped. Port B posts `b_din` and the full flag is `b_mb2_full_n`. Port A collects on `a_dout` and the waiting flag is `a_mb2_wait_n`.
- R9: The two mailboxes are independent. Posts to both in the same interval are each delivered intact to the opposite port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, asynchronous to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs | input | 1 | Port A chip select, active high |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 post, 0 collect |
| a_mb | input | 1 | Port A mailbox select |
| a_din | input | W | Word posted by port A into mailbox 1 |
| a_dout | output | W | Word collected by port A from mailbox 2 |
| a_mb1_full_n | output | 1 | Mailbox 1 full, active low, clk_a domain |
| a_mb2_wait_n | output | 1 | Mailbox 2 word waiting, active low, clk_a domain |
| b_cs | input | 1 | Port B chip select, active high |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction: 1 post, 0 collect |
| b_mb | input | 1 | Port B mailbox select |
| b_din | input | W | Word posted by port B into mailbox 2 |
| b_dout | output | W | Word collected by port B from mailbox 1 |
| b_mb2_full_n | output | 1 | Mailbox 2 full, active low, clk_b domain |
| b_mb1_wait_n | output | 1 | Mailbox 1 word waiting, active low, clk_a → clk_b synchronized |

## Verification
The hardest case to reach is an overwrite attempt. The writer must post again while its full flag is still low, and then show at the reader's output that the first word survived. The stimulus posts once, then issues a second post with a different word before any collect. Only after that does it collect and compare against the first word. A further post after the full flag has cleared confirms that the blocking lifts. The clocks run at unrelated periods, so the waiting and full flags are polled with bounded windows instead of fixed offsets. Both directions are also posted at the same time from parallel threads to exercise independence.

// File: rtl/dual_mailbox.sv
module dual_mailbox #(
  parameter int W    = 36,
  parameter int SYNC = 2
) (
  input  logic         clk_a,
  input  logic         clk_b,
  input  logic         rst_n,
  input  logic         a_cs,
  input  logic         a_en,
  input  logic         a_wr,
  input  logic         a_mb,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_mb1_full_n,
  output logic         a_mb2_wait_n,
  input  logic         b_cs,
  input  logic         b_en,
  input  logic         b_wr,
  input  logic         b_mb,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] b_dout,
  output logic         b_mb2_full_n,
  output logic         b_mb1_wait_n
);

  logic a_post, a_take, b_post, b_take;
  assign a_post = a_cs & a_en & a_mb & a_wr;
  assign a_take = a_cs & a_en & a_mb & ~a_wr;
  assign b_post = b_cs & b_en & b_mb & b_wr;
  assign b_take = b_cs & b_en & b_mb & ~b_wr;

  logic [W-1:0]    mb1_q, mb2_q;
  logic            mb1_wt, mb1_rt, mb2_wt, mb2_rt;
  logic [SYNC-1:0] mb1_ws, mb1_rs, mb2_ws, mb2_rs;

  assign a_mb1_full_n = ~(mb1_wt ^ mb1_rs[SYNC-1]);
  assign b_mb1_wait_n = ~(mb1_ws[SYNC-1] ^ mb1_rt);
  assign b_mb2_full_n = ~(mb2_wt ^ mb2_rs[SYNC-1]);
  assign a_mb2_wait_n = ~(mb2_ws[SYNC-1] ^ mb2_rt);

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      mb1_q  <= '0;
      mb1_wt <= 1'b0;
      mb1_rs <= '0;
      mb2_ws <= '0;
      mb2_rt <= 1'b0;
      a_dout <= '0;
    end else begin
      mb1_rs <= {mb1_rs[SYNC-2:0], mb1_rt};
      mb2_ws <= {mb2_ws[SYNC-2:0], mb2_wt};
      if (a_post && a_mb1_full_n) begin
        mb1_q  <= a_din;
        mb1_wt <= ~mb1_wt;
      end
      if (a_take && !a_mb2_wait_n) begin
        a_dout <= mb2_q;
        mb2_rt <= ~mb2_rt;
      end
    end
  end

  always_ff @(posedge clk_b or negedge rst_n) begin
    if (!rst_n) begin
      mb2_q  <= '0;
      mb2_wt <= 1'b0;
      mb2_rs <= '0;
      mb1_ws <= '0;
      mb1_rt <= 1'b0;
      b_dout <= '0;
    end else begin
      mb2_rs <= {mb2_rs[SYNC-2:0], mb2_rt};
      mb1_ws <= {mb1_ws[SYNC-2:0], mb1_wt};
      if (b_post && b_mb2_full_n) begin
        mb2_q  <= b_din;
        mb2_wt <= ~mb2_wt;
      end
      if (b_take && !b_mb1_wait_n) begin
        b_dout <= mb1_q;
        mb1_rt <= ~mb1_rt;
      end
    end
  end

endmodule

// File: rtl/mailbox_checker.sv
module mailbox_checker #(
  parameter int W = 36
) (
  input logic         clk_a,
  input logic         clk_b,
  input logic         rst_n,
  input logic         a_cs,
  input logic         a_en,
  input logic         a_wr,
  input logic         a_mb,
  input logic         b_cs,
  input logic         b_en,
  input logic         b_wr,
  input logic         b_mb,
  input logic [W-1:0] a_dout,
  input logic [W-1:0] b_dout,
  input logic         a_mb1_full_n,
  input logic         a_mb2_wait_n,
  input logic         b_mb2_full_n,
  input logic         b_mb1_wait_n,
  input logic [W-1:0] mb1_q,
  input logic [W-1:0] mb2_q
);

  logic ap, at, bp, bt;
  assign ap = a_cs & a_en & a_mb & a_wr;
  assign at = a_cs & a_en & a_mb & ~a_wr;
  assign bp = b_cs & b_en & b_mb & b_wr;
  assign bt = b_cs & b_en & b_mb & ~b_wr;

  always_comb begin
    if (!rst_n) begin
      a_reset_r1: assert (a_mb1_full_n && a_mb2_wait_n && a_dout == '0);
      b_reset_r1: assert (b_mb2_full_n && b_mb1_wait_n && b_dout == '0);
    end
  end

  p_post_sets_full_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
    (ap && a_mb1_full_n) |=> !a_mb1_full_n);

  p_take_clears_wait_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
    (bt && !b_mb1_wait_n) |=> b_mb1_wait_n);

  p_no_overwrite_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
    !a_mb1_full_n |=> $stable(mb1_q));

  p_empty_take_holds_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
    (bt && b_mb1_wait_n) |=> $stable(b_dout));

  p_idle_keeps_mb1_r7: assert property (@(posedge clk_a) disable iff (!rst_n)
    !ap |=> $stable(mb1_q));

  p_post_sets_full_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
    (bp && b_mb2_full_n) |=> !b_mb2_full_n);

  p_take_clears_wait_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
    (at && !a_mb2_wait_n) |=> a_mb2_wait_n);

  p_no_overwrite_mb2_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
    !b_mb2_full_n |=> $stable(mb2_q));

endmodule

bind dual_mailbox mailbox_checker #(.W(W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .a_cs(a_cs), .a_en(a_en), .a_wr(a_wr), .a_mb(a_mb),
  .b_cs(b_cs), .b_en(b_en), .b_wr(b_wr), .b_mb(b_mb),
  .a_dout(a_dout), .b_dout(b_dout),
  .a_mb1_full_n(a_mb1_full_n), .a_mb2_wait_n(a_mb2_wait_n),
  .b_mb2_full_n(b_mb2_full_n), .b_mb1_wait_n(b_mb1_wait_n),
  .mb1_q(mb1_q), .mb2_q(mb2_q)
);

// File: tb/dual_mailbox_test.sv
`timescale 1ns/1ps
module dual_mailbox_test;
  localparam int W = 36;
  localparam int SYNC = 2;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic a_cs = 0, a_en = 0, a_wr = 0, a_mb = 0;
  logic b_cs = 0, b_en = 0, b_wr = 0, b_mb = 0;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_mb1_full_n, a_mb2_wait_n, b_mb2_full_n, b_mb1_wait_n;

  int checks = 0, fails = 0;

  always #4 clk_a = ~clk_a;
  always #6.5 clk_b = ~clk_b;

  dual_mailbox #(.W(W), .SYNC(SYNC)) uut (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_access(input logic wr, input logic mb, input logic cs, input logic [W-1:0] d);
    @(negedge clk_a);
    a_cs = cs; a_en = 1; a_wr = wr; a_mb = mb; a_din = d;
    @(negedge clk_a);
    a_cs = 0; a_en = 0; a_wr = 0; a_mb = 0;
  endtask

  task automatic b_access(input logic wr, input logic mb, input logic cs, input logic [W-1:0] d);
    @(negedge clk_b);
    b_cs = cs; b_en = 1; b_wr = wr; b_mb = mb; b_din = d;
    @(negedge clk_b);
    b_cs = 0; b_en = 0; b_wr = 0; b_mb = 0;
  endtask

  task automatic wait_b1(input string req, input logic v);
    int n = 0;
    while (b_mb1_wait_n !== v && n < SYNC + 2) begin @(negedge clk_b); n++; end
    check(req, {35'd0, b_mb1_wait_n}, {35'd0, v});
  endtask

  task automatic wait_a1(input string req, input logic v);
    int n = 0;
    while (a_mb1_full_n !== v && n < SYNC + 2) begin @(negedge clk_a); n++; end
    check(req, {35'd0, a_mb1_full_n}, {35'd0, v});
  endtask

  task automatic wait_a2(input string req, input logic v);
    int n = 0;
    while (a_mb2_wait_n !== v && n < SYNC + 2) begin @(negedge clk_a); n++; end
    check(req, {35'd0, a_mb2_wait_n}, {35'd0, v});
  endtask

  task automatic wait_b2(input string req, input logic v);
    int n = 0;
    while (b_mb2_full_n !== v && n < SYNC + 2) begin @(negedge clk_b); n++; end
    check(req, {35'd0, b_mb2_full_n}, {35'd0, v});
  endtask

  task automatic t_reset;
    check("R1 a_mb1_full_n", {35'd0, a_mb1_full_n}, 36'd1);
    check("R1 b_mb1_wait_n", {35'd0, b_mb1_wait_n}, 36'd1);
    check("R1 b_mb2_full_n", {35'd0, b_mb2_full_n}, 36'd1);
    check("R1 a_mb2_wait_n", {35'd0, a_mb2_wait_n}, 36'd1);
    check("R1 a_dout", a_dout, '0);
    check("R1 b_dout", b_dout, '0);
  endtask

  task automatic t_a_to_b(input logic [W-1:0] d);
    a_access(1, 1, 1, d);
    check("R2 full after post", {35'd0, a_mb1_full_n}, 36'd0);
    wait_b1("R3 wait flag at B", 0);
    b_access(0, 1, 1, '0);
    check("R4 b_dout", b_dout, d);
    check("R4 wait cleared", {35'd0, b_mb1_wait_n}, 36'd1);
    wait_a1("R4 full cleared at A", 1);
  endtask

  task automatic t_overwrite;
    a_access(1, 1, 1, 36'h0_1234_5678);
    a_access(1, 1, 1, 36'hF_EEEE_EEEE);
    wait_b1("R5 wait flag", 0);
    b_access(0, 1, 1, '0);
    check("R5 first word kept", b_dout, 36'h0_1234_5678);
    wait_a1("R5 full cleared", 1);
    t_a_to_b(36'hF_EEEE_EEEE);
  endtask

  task automatic t_empty_take;
    logic [W-1:0] prev = b_dout;
    b_access(0, 1, 1, '0);
    check("R6 b_dout holds", b_dout, prev);
    prev = a_dout;
    a_access(0, 1, 1, '0);
    check("R6 a_dout holds", a_dout, prev);
  endtask

  task automatic t_ignored;
    logic [W-1:0] prev = b_dout;
    a_access(1, 0, 1, 36'h5_5555_5555);
    a_access(1, 1, 0, 36'h6_6666_6666);
    repeat (SYNC + 3) @(negedge clk_b);
    check("R7 a full untouched", {35'd0, a_mb1_full_n}, 36'd1);
    check("R7 b wait untouched", {35'd0, b_mb1_wait_n}, 36'd1);
    b_access(0, 0, 1, '0);
    check("R7 b_dout unchanged", b_dout, prev);
  endtask

  task automatic t_b_to_a(input logic [W-1:0] d);
    b_access(1, 1, 1, d);
    check("R8 full after post", {35'd0, b_mb2_full_n}, 36'd0);
    b_access(1, 1, 1, ~d);
    wait_a2("R8 wait flag at A", 0);
    a_access(0, 1, 1, '0);
    check("R8 a_dout", a_dout, d);
    check("R8 wait cleared", {35'd0, a_mb2_wait_n}, 36'd1);
    wait_b2("R8 full cleared at B", 1);
  endtask

  task automatic t_concurrent;
    fork
      a_access(1, 1, 1, 36'hA_0000_000A);
      b_access(1, 1, 1, 36'hB_0000_000B);
    join
    wait_b1("R9 wait at B", 0);
    wait_a2("R9 wait at A", 0);
    fork
      b_access(0, 1, 1, '0);
      a_access(0, 1, 1, '0);
    join
    check("R9 b_dout", b_dout, 36'hA_0000_000A);
    check("R9 a_dout", a_dout, 36'hB_0000_000B);
    wait_a1("R9 full A cleared", 1);
    wait_b2("R9 full B cleared", 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_a);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #30;
    t_reset;
    #3 rst_n = 1;
    repeat (3) @(negedge clk_a);
    t_a_to_b(36'h9_8765_4321);
    t_overwrite;
    t_empty_take;
    t_ignored;
    t_b_to_a(36'h3_C3C3_C3C3);
    t_concurrent;
    repeat (4) @(negedge clk_b);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule